// File: doc/BRIEF.md
# General-Purpose I/O Port with Alternate-Function Output Select

A memory-mapped port that controls a group of pads (16 by default) through a plain 32-bit register bus: word address, write strobe, write data and combinational read data. Each pin carries a 2-bit mode. A pin can be a sampled input, a software-driven output, the output of one of 16 peripheral sources, or an analog pin whose digital driver is switched off. The port also holds a drive style, a slew-rate class and a pull selection for each pin, and it presents them to the pad ring as static control outputs.

Software drives the pins either by writing the output data word whole, or by writing one word to the atomic set/clear register, which can raise some pins and lower others in a single bus cycle with no read-modify-write. Pad levels pass through a two-flop synchronizer before they can be read. In alternate mode, a 4-bit selector for each pin picks the value and enable from that pin's own bank of 16 peripheral lines. The selectors for pins 0-7 sit in the first selector word and those for pins 8-15 in the second.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset all registers read zero. Every pin is an input with no pull, push-pull, low speed, and has its output enable low.
- R2: The pin mode word (byte offset 0x00, pin n at bits [2n+1:2n]), the speed word (0x08, same layout), the pull word (0x0C, same layout) and the drive-style word (0x04, pin n at bit n, 1 = open-drain) read back what was written. They appear unchanged on pad_speed_o, pad_pull_o and pad_odrain_o.
- R3: A write to the output data word (0x14) loads bits [15:0]. Bits [31:16] read back as zero. A pin in output mode (code 1) drives its output data bit with output enable high when push-pull.
- R4: A write to the set/clear word (0x18) sets output bit n for each 1 in bit n and clears output bit n for each 1 in bit n+16. A 0 leaves the bit unchanged, and when both bits of a pin are 1 the set wins. The word reads back as zero.
- R5: The input data word (0x10) returns pad_in_i with pin n at bit n, delayed by two clock edges. The word cannot be written.
- R6: A pin in alternate mode (code 2) drives alt_out_i[16n+s] with enable alt_oe_i[16n+s]. The selector s is taken from bits [4(n mod 8)+3:4(n mod 8)] of the word at 0x20 for pins 0-7, and of the word at 0x24 for pins 8-15.
- R7: An open-drain pin asserts output enable only while its driven value is 0, and never while it drives a 1.
- R8: A pin in input mode (code 0) or analog mode (code 3) keeps output enable low.
- R9: Offset 0x1C and every offset above 0x24 read as zero, and writes to them change no state. The two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W (8) | Byte address of the register |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data of the addressed word, combinational |
| pad_in_i | input | NUM_PINS (16) | Pad input levels, asynchronous |
| alt_out_i | input | NUM_PINS*NUM_ALT (256) | Peripheral output values, pin n source k at bit 16n+k |
| alt_oe_i | input | NUM_PINS*NUM_ALT (256) | Peripheral output enables, same layout |
| pad_out_o | output | NUM_PINS (16) | Value presented to each pad driver |
| pad_oe_o | output | NUM_PINS (16) | Pad driver enable |
| pad_odrain_o | output | NUM_PINS (16) | Drive style per pin, 1 = open-drain |
| pad_speed_o | output | 2*NUM_PINS (32) | Slew class per pin, 2 bits each |
| pad_pull_o | output | 2*NUM_PINS (32) | Pull selection per pin, 2 bits each |

## Verification
The case that is hardest to reach is the one where the mode, drive style, selector and peripheral lines of one pin all line up. Examples are an open-drain alternate pin whose selected source drives a 1, or a set/clear word that names the same pin in both halves. Directed writes build each of these combinations on purpose. A long run of random register writes then follows, with peripheral lines and pad levels redrawn every step. After each step all pad outputs and a random register readback are compared against a bench model, so that combinations of modes and selectors appear across all pins together.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_ALTFN  = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  // word indices (byte offset / 4)
  localparam int unsigned WI_MODE    = 0;
  localparam int unsigned WI_OTYPE   = 1;
  localparam int unsigned WI_SPEED   = 2;
  localparam int unsigned WI_PULL    = 3;
  localparam int unsigned WI_IDR     = 4;
  localparam int unsigned WI_ODR     = 5;
  localparam int unsigned WI_SETCLR  = 6;
  localparam int unsigned WI_LOCK    = 7;
  localparam int unsigned WI_AF_BASE = 8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SEL_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]       idr_i,
  output logic [2*NUM_PINS-1:0]     mode_o,
  output logic [NUM_PINS-1:0]       otype_o,
  output logic [2*NUM_PINS-1:0]     speed_o,
  output logic [2*NUM_PINS-1:0]     pull_o,
  output logic [NUM_PINS-1:0]       odr_o,
  output logic [NUM_PINS*SEL_W-1:0] sel_o
);
  localparam int unsigned WIDX_W      = ADDR_W - 2;
  localparam int unsigned FIELD_W     = 2 * NUM_PINS;
  localparam int unsigned SEL_PER_REG = DATA_W / SEL_W;
  localparam int unsigned AF_REGS     = (NUM_PINS + SEL_PER_REG - 1) / SEL_PER_REG;

  logic [WIDX_W-1:0]  widx;
  logic               unused_addr_bits;
  logic [FIELD_W-1:0] mode_q, speed_q, pull_q;
  logic [NUM_PINS-1:0] otype_q, odr_q;
  logic [DATA_W-1:0]  af_q [AF_REGS];

  assign widx             = addr_i[ADDR_W-1:2];
  assign unused_addr_bits = ^addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
    end else if (we_i) begin
      case (widx)
        WIDX_W'(WI_MODE):   mode_q  <= wdata_i[FIELD_W-1:0];
        WIDX_W'(WI_OTYPE):  otype_q <= wdata_i[NUM_PINS-1:0];
        WIDX_W'(WI_SPEED):  speed_q <= wdata_i[FIELD_W-1:0];
        WIDX_W'(WI_PULL):   pull_q  <= wdata_i[FIELD_W-1:0];
        WIDX_W'(WI_ODR):    odr_q   <= wdata_i[NUM_PINS-1:0];
        // set half applied last so it wins over clear
        WIDX_W'(WI_SETCLR): odr_q   <= (odr_q & ~wdata_i[NUM_PINS +: NUM_PINS])
                                       | wdata_i[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < AF_REGS; g++) begin : g_af
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) af_q[g] <= '0;
      else if (we_i && widx == WIDX_W'(WI_AF_BASE + g)) af_q[g] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    assign sel_o[p*SEL_W +: SEL_W] =
      af_q[p/SEL_PER_REG][(p%SEL_PER_REG)*SEL_W +: SEL_W];
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      WIDX_W'(WI_MODE):  rdata_o = DATA_W'(mode_q);
      WIDX_W'(WI_OTYPE): rdata_o = DATA_W'(otype_q);
      WIDX_W'(WI_SPEED): rdata_o = DATA_W'(speed_q);
      WIDX_W'(WI_PULL):  rdata_o = DATA_W'(pull_q);
      WIDX_W'(WI_IDR):   rdata_o = DATA_W'(idr_i);
      WIDX_W'(WI_ODR):   rdata_o = DATA_W'(odr_q);
      default: begin
        for (int g = 0; g < AF_REGS; g++) begin
          if (widx == WIDX_W'(WI_AF_BASE + g)) rdata_o = af_q[g];
        end
      end
    endcase
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign speed_o = speed_q;
  assign pull_o  = pull_q;
  assign odr_o   = odr_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_ALT = 16,
  parameter int unsigned SEL_W   = 4
) (
  input  logic [1:0]         mode_i,
  input  logic               odrain_i,
  input  logic               odr_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_ALT-1:0] alt_out_i,
  input  logic [NUM_ALT-1:0] alt_oe_i,
  output logic               pad_out_o,
  output logic               pad_oe_o
);
  pin_mode_e mode;
  logic      val, en;

  assign mode = pin_mode_e'(mode_i);

  always_comb begin
    val = odr_i;
    en  = 1'b0;
    case (mode)
      PM_OUTPUT: en = 1'b1;
      PM_ALTFN: begin
        val = alt_out_i[sel_i];
        en  = alt_oe_i[sel_i];
      end
      default: ;
    endcase
  end

  assign pad_out_o = val;
  assign pad_oe_o  = odrain_i ? (en & ~val) : en;
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_ALT  = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_we_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  input  logic [NUM_PINS-1:0]         pad_in_i,
  input  logic [NUM_PINS*NUM_ALT-1:0] alt_out_i,
  input  logic [NUM_PINS*NUM_ALT-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0]         pad_out_o,
  output logic [NUM_PINS-1:0]         pad_oe_o,
  output logic [NUM_PINS-1:0]         pad_odrain_o,
  output logic [2*NUM_PINS-1:0]       pad_speed_o,
  output logic [2*NUM_PINS-1:0]       pad_pull_o
);
  localparam int unsigned SEL_W = $clog2(NUM_ALT);

  logic [2*NUM_PINS-1:0]     mode_w;
  logic [NUM_PINS-1:0]       odr_w, idr_w, otype_w;
  logic [NUM_PINS*SEL_W-1:0] sel_w;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (idr_w)
  );

  gpio_port_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .idr_i   (idr_w),
    .mode_o  (mode_w),
    .otype_o (otype_w),
    .speed_o (pad_speed_o),
    .pull_o  (pad_pull_o),
    .odr_o   (odr_w),
    .sel_o   (sel_w)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gpio_pin_mux #(.NUM_ALT(NUM_ALT), .SEL_W(SEL_W)) u_mux (
      .mode_i    (mode_w[2*n +: 2]),
      .odrain_i  (otype_w[n]),
      .odr_i     (odr_w[n]),
      .sel_i     (sel_w[n*SEL_W +: SEL_W]),
      .alt_out_i (alt_out_i[n*NUM_ALT +: NUM_ALT]),
      .alt_oe_i  (alt_oe_i[n*NUM_ALT +: NUM_ALT]),
      .pad_out_o (pad_out_o[n]),
      .pad_oe_o  (pad_oe_o[n])
    );
  end

  assign pad_odrain_o = otype_w;
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic                  bus_we_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [DATA_W-1:0]     bus_rdata_o,
  input logic [NUM_PINS-1:0]   pad_in_i,
  input logic [NUM_PINS-1:0]   pad_out_o,
  input logic [NUM_PINS-1:0]   pad_oe_o,
  input logic [NUM_PINS-1:0]   pad_odrain_o,
  input logic [2*NUM_PINS-1:0] mode_w,
  input logic [NUM_PINS-1:0]   odr_w,
  input logic [NUM_PINS-1:0]   idr_w
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]   widx;
  logic                unused_chk_bits;
  logic                setclr_wr, lock_rd;
  logic [NUM_PINS-1:0] idle_mask;
  logic [1:0]          age_q;

  assign widx            = bus_addr_i[ADDR_W-1:2];
  assign unused_chk_bits = ^bus_addr_i[1:0];
  assign setclr_wr       = bus_we_i && widx == WIDX_W'(6);
  assign lock_rd         = !bus_we_i && widx == WIDX_W'(7);

  always_comb begin
    for (int n = 0; n < NUM_PINS; n++)
      idle_mask[n] = ~(mode_w[2*n+1] ^ mode_w[2*n]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_oe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & idle_mask) == '0);

  assert_od_no_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_odrain_o & pad_out_o) == '0);

  assert_set_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setclr_wr |=> (odr_w & $past(bus_wdata_i[NUM_PINS-1:0])) == $past(bus_wdata_i[NUM_PINS-1:0]));

  assert_clr_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setclr_wr |=> (odr_w & $past(bus_wdata_i[NUM_PINS +: NUM_PINS])
                   & ~$past(bus_wdata_i[NUM_PINS-1:0])) == '0);

  assert_lock_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rd |-> bus_rdata_o == '0);

  assert_sync_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q >= 2'd2 |-> idr_w == $past(pad_in_i, 2));
endmodule

bind gpio_port_mux gpio_port_mux_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .pad_in_i     (pad_in_i),
  .pad_out_o    (pad_out_o),
  .pad_oe_o     (pad_oe_o),
  .pad_odrain_o (pad_odrain_o),
  .mode_w       (mode_w),
  .odr_w        (odr_w),
  .idr_w        (idr_w)
);

// File: tb/gpio_port_mux_tb_top.sv
module gpio_port_mux_tb_top;
  localparam int NP = 16;
  localparam int NA = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP*NA-1:0] alt_out = '0, alt_oe = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_odrain;
  logic [2*NP-1:0] pad_speed, pad_pull;

  always #2 clk = ~clk;

  gpio_port_mux dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_odrain_o(pad_odrain), .pad_speed_o(pad_speed),
    .pad_pull_o(pad_pull)
  );

  // bench model
  logic [31:0] m_mode, m_speed, m_pull, m_afl, m_afh;
  logic [15:0] m_otype, m_odr, m_s1, m_s2;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin m_s1 <= '0; m_s2 <= '0; end
    else begin m_s1 <= pad_in; m_s2 <= m_s1; end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int idx);
    case (idx)
      0: return m_mode;
      1: return {16'h0, m_otype};
      2: return m_speed;
      3: return m_pull;
      4: return {16'h0, m_s2};
      5: return {16'h0, m_odr};
      8: return m_afl;
      9: return m_afh;
      default: return 32'h0;
    endcase
  endfunction

  // {oe, out}
  function automatic logic [31:0] exp_pads();
    logic [15:0] o, e;
    for (int n = 0; n < NP; n++) begin
      logic [3:0] s;
      logic v, en;
      s = (n < 8) ? m_afl[4*n +: 4] : m_afh[4*(n-8) +: 4];
      v = m_odr[n];
      en = 1'b0;
      case (m_mode[2*n +: 2])
        2'd1: en = 1'b1;
        2'd2: begin v = alt_out[n*NA + int'(s)]; en = alt_oe[n*NA + int'(s)]; end
        default: ;
      endcase
      o[n] = v;
      e[n] = m_otype[n] ? (en & ~v) : en;
    end
    return {e, o};
  endfunction

  task automatic check_pads(string tag);
    logic [31:0] p;
    p = exp_pads();
    chk({tag, " pad_out"}, {16'h0, pad_out}, {16'h0, p[15:0]});
    chk({tag, " pad_oe"}, {16'h0, pad_oe}, {16'h0, p[31:16]});
    chk({tag, " R2 odrain"}, {16'h0, pad_odrain}, {16'h0, m_otype});
    chk({tag, " R2 speed"}, pad_speed, m_speed);
    chk({tag, " R2 pull"}, pad_pull, m_pull);
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    addr = AW'(idx << 2); we = 1'b1; wdata = d;
    @(posedge clk);
    case (idx)
      0: m_mode = d;
      1: m_otype = d[15:0];
      2: m_speed = d;
      3: m_pull = d;
      5: m_odr = d[15:0];
      6: m_odr = (m_odr & ~d[31:16]) | d[15:0];
      8: m_afl = d;
      9: m_afh = d;
      default: ;
    endcase
    #1 we = 1'b0;
  endtask

  task automatic rd(int idx, string tag);
    @(negedge clk);
    addr = AW'(idx << 2); we = 1'b0;
    #1 chk(tag, rdata, exp_rd(idx));
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    {m_mode, m_speed, m_pull, m_afl, m_afh, m_otype, m_odr} = '0;
    repeat (3) @(posedge clk);
    #1 check_pads("R1 in reset");
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 12; i++) rd(i, "R1 reset read");
    #1 check_pads("R1 after reset");

    // R2 config words and pad controls
    wr(0, 32'h5555_5555); wr(2, 32'hE4E4_1B1B); wr(3, 32'h9999_6666);
    rd(0, "R2 mode"); rd(2, "R2 speed"); rd(3, "R2 pull");
    wr(1, 32'hFFFF_00F0); rd(1, "R2 otype");
    check_pads("R2 pads");
    wr(1, 32'h0);

    // R3 output data word
    wr(5, 32'hFFFF_A5C3); rd(5, "R3 odr read");
    #1 chk("R3 pad_out", {16'h0, pad_out}, 32'h0000_A5C3);
    chk("R3 pad_oe", {16'h0, pad_oe}, 32'h0000_FFFF);

    // R4 set/clear
    wr(6, 32'h00FF_0F00); rd(5, "R4 set/clear");
    chk("R4 odr value", rdata, 32'h0000_AF00);
    wr(6, 32'h8001_0001); rd(5, "R4 set wins");
    chk("R4 set wins value", rdata, 32'h0000_2F01);
    wr(6, 32'h0); rd(5, "R4 zero write no change");
    rd(6, "R4 setclr reads zero");

    // R7 open drain in output mode
    wr(1, 32'h0000_FFFF);
    #1 chk("R7 od oe", {16'h0, pad_oe}, {16'h0, ~m_odr});
    check_pads("R7 pads");

    // R8 input/analog
    wr(0, 32'hFFFF_0000);
    #1 chk("R8 oe off", {16'h0, pad_oe}, 32'h0);
    wr(1, 32'h0);

    // R6 alternate select
    wr(0, 32'hAAAA_AAAA); wr(9, 32'h0000_00B0);
    @(negedge clk);
    alt_out = '0; alt_oe = '0;
    alt_out[9*NA + 11] = 1'b1; alt_oe[9*NA + 11] = 1'b1;
    alt_oe[3*NA] = 1'b1;
    #1 chk("R6 pin9 out", {16'h0, pad_out}, 32'h0000_0200);
    chk("R6 pin9/pin3 oe", {16'h0, pad_oe}, 32'h0000_0208);
    wr(8, 32'h0000_5000);  // pin3 sel 5
    #1 chk("R6 pin3 reselect", {16'h0, pad_oe}, 32'h0000_0200);
    wr(1, 32'h0000_0200);  // pin9 open-drain, driving 1
    #1 chk("R7 alt od high", {16'h0, pad_oe}, 32'h0);
    check_pads("R6 pads");

    // R5 input synchronizer
    @(negedge clk); pad_in = 16'h1234;
    rd(4, "R5 one edge");
    chk("R5 not yet", rdata, 32'h0);
    rd(4, "R5 two edges");
    chk("R5 visible", rdata, 32'h0000_1234);
    wr(4, 32'hFFFF_FFFF); rd(4, "R5 write ignored");

    // R9 lock/unmapped
    wr(7, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF); wr(63, 32'hFFFF_FFFF);
    rd(7, "R9 lock"); rd(11, "R9 unmapped"); rd(63, "R9 top");
    for (int i = 0; i < 10; i++) rd(i, "R9 no side effect");
    check_pads("R9 pads");
    @(negedge clk); addr = 8'h17; #1 chk("R9 low addr bits", rdata, {16'h0, m_odr});

    // random
    for (int it = 0; it < 400; it++) begin
      int idx;
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        alt_out[k*32 +: 32] = $urandom;
        alt_oe[k*32 +: 32]  = $urandom;
      end
      if ($urandom % 4 == 0) pad_in = 16'($urandom);
      idx = $urandom % 12;
      wr(idx, $urandom);
      #1 check_pads("R6 R3 R7 R8 random pads");
      rd($urandom % 12, "R2 R3 R4 R5 R9 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule